// File: doc/BRIEF.md
# Segment-Register Address Extender

This block widens a 32-bit program virtual address into a system-wide virtual address. A file of sixteen segment registers holds one segment identifier each. The four most significant address bits choose a register, and the chosen identifier is placed above the remaining 28 offset bits. The result goes to a translation buffer downstream. That buffer matches on segment identifiers, so address-space identity comes from the selected segment and not from one tag per process.

Software loads identifiers through a write port that carries a register index, a value and a privilege flag. A run-time protection input decides who may load them. With protection off, any write is accepted. With protection on, only privileged writes are accepted. A refused write leaves the register file untouched and raises a one-cycle violation pulse.

The identifier width is a parameter: 12 bits for the narrow build, which gives a 40-bit result, and 24 bits for the wide build, which gives a 52-bit result. A lookup is registered, so the extended address appears one cycle after the address is presented. A write that lands in the same cycle as a lookup of the same register forwards its new value into that lookup.

Top module: `seg_addr_extender`

## Requirements
- R1: After reset, extValid and violation are 0, and every segment register holds identifier 0.
- R2: One cycle after vaValid is sampled high, extAddr equals {identifier of the selected register, va[27:0]}. The identifier field is SID_W bits wide: 12 bits gives a 40-bit extAddr, 24 bits gives a 52-bit extAddr.
- R3: extValid equals the vaValid value sampled at the previous clock edge.
- R4: va[31:28] selects segment register 0 to 15, and each of the sixteen registers returns its own identifier.
- R5: With protectOn = 0, a write (wrEn = 1) stores wrSid into register wrIdx whatever the value of wrPriv.
- R6: When a write is accepted in the same cycle as a lookup whose va[31:28] equals wrIdx, that lookup returns the new wrSid.
- R7: With protectOn = 1, a write with wrPriv = 0 is dropped, and the register keeps its old identifier.
- R8: violation is 1 in the cycle after a write with protectOn = 1 and wrPriv = 0, and 0 in every other cycle.
- R9: With protectOn = 1, a write with wrPriv = 1 is stored and raises no violation.
- R10: While vaValid is 0, extAddr holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protectOn | input | 1 | 1 = only privileged writes may change segment registers |
| wrEn | input | 1 | Segment-register write request |
| wrPriv | input | 1 | Write comes from privileged code |
| wrIdx | input | SEL_W (4) | Register index to write |
| wrSid | input | SID_W (12) | Identifier to store |
| vaValid | input | 1 | Address input is valid |
| va | input | VA_W (32) | Program virtual address |
| extValid | output | 1 | Extended address is valid |
| extAddr | output | SID_W+VA_W-SEL_W (40) | Identifier joined with the offset |
| violation | output | 1 | One-cycle pulse for a refused write |

## Verification
The first directed pattern loads all sixteen registers with distinct values and then reads them back by address. This shows whether selection uses the correct top bits, and whether writes reach the correct register. A write and a lookup to the same index in the same cycle separates forwarding from a stale read. A write and a lookup to different indices separates correct forwarding from forwarding on every write. Protected writes, both unprivileged and privileged, are each followed by a read-back, so a dropped write can be told apart from an accepted one at the output. Seeded random traffic then mixes every input, and it drives a narrow and a wide instance side by side so that truncation of the identifier shows up.

// File: rtl/seg_ext_pkg.sv
package seg_ext_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrCommit;  // write accepted this cycle
    logic fwdHit;    // accepted write targets the register being looked up
    logic lookup;    // capture a new extended address
  } segStrobe_t;
endpackage

// File: rtl/seg_ext_ctrl.sv
module seg_ext_ctrl
  import seg_ext_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             protectOn,
  input  logic             wrEn,
  input  logic             wrPriv,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic             vaValid,
  input  logic [SEL_W-1:0] vaSel,
  output segStrobe_t       strobe,
  output logic             violation
);
  logic writeAllowed;
  logic writeDenied;

  always_comb begin
    writeAllowed = !protectOn || wrPriv;
    writeDenied  = wrEn && !writeAllowed;
    strobe.wrCommit = wrEn && writeAllowed;
    strobe.lookup   = vaValid;
    strobe.fwdHit   = wrEn && writeAllowed && vaValid && (wrIdx == vaSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) violation <= 1'b0;
    else       violation <= writeDenied;
  end
endmodule

// File: rtl/seg_ext_datapath.sv
module seg_ext_datapath
  import seg_ext_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEL_W = 4,
  parameter int SID_W = 12,
  localparam int NUM_SEG = 1 << SEL_W,
  localparam int OFF_W   = VA_W - SEL_W,
  localparam int EXT_W   = SID_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  segStrobe_t       strobe,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic [SID_W-1:0] wrSid,
  input  logic [VA_W-1:0]  va,
  output logic             extValid,
  output logic [EXT_W-1:0] extAddr
);
  logic [SID_W-1:0] sidReg [NUM_SEG];
  logic [SID_W-1:0] sidSel;
  logic [SEL_W-1:0] vaSel;
  logic [OFF_W-1:0] vaOff;

  assign vaSel = va[VA_W-1 -: SEL_W];
  assign vaOff = va[OFF_W-1:0];

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sidReg[g] <= '0;
      end else if (strobe.wrCommit && (wrIdx == SEL_W'(g))) begin
        sidReg[g] <= wrSid;
      end
    end
  end

  always_comb begin
    sidSel = sidReg[vaSel];
    if (strobe.fwdHit) sidSel = wrSid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extValid <= 1'b0;
      extAddr  <= '0;
    end else begin
      extValid <= strobe.lookup;
      if (strobe.lookup) extAddr <= {sidSel, vaOff};
    end
  end
endmodule

// File: rtl/seg_addr_extender.sv
module seg_addr_extender
  import seg_ext_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEL_W = 4,
  parameter int SID_W = 12,
  localparam int EXT_W = SID_W + VA_W - SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             protectOn,
  input  logic             wrEn,
  input  logic             wrPriv,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic [SID_W-1:0] wrSid,
  input  logic             vaValid,
  input  logic [VA_W-1:0]  va,
  output logic             extValid,
  output logic [EXT_W-1:0] extAddr,
  output logic             violation
);
  segStrobe_t strobe;

  seg_ext_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .protectOn(protectOn), .wrEn(wrEn),
    .wrPriv(wrPriv), .wrIdx(wrIdx), .vaValid(vaValid),
    .vaSel(va[VA_W-1 -: SEL_W]), .strobe(strobe), .violation(violation)
  );

  seg_ext_datapath #(.VA_W(VA_W), .SEL_W(SEL_W), .SID_W(SID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .wrSid(wrSid),
    .va(va), .extValid(extValid), .extAddr(extAddr)
  );
endmodule

// File: rtl/seg_ext_checker.sv
module seg_ext_checker #(
  parameter int VA_W  = 32,
  parameter int SEL_W = 4,
  parameter int SID_W = 12,
  localparam int OFF_W = VA_W - SEL_W,
  localparam int EXT_W = SID_W + OFF_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             protectOn,
  input logic             wrEn,
  input logic             wrPriv,
  input logic [SEL_W-1:0] wrIdx,
  input logic [SID_W-1:0] wrSid,
  input logic             vaValid,
  input logic [VA_W-1:0]  va,
  input logic             extValid,
  input logic [EXT_W-1:0] extAddr,
  input logic             violation
);
  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    vaValid |=> extValid);
  p_valid_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    !vaValid |=> !extValid);
  p_offset_r2: assert property (@(posedge clk) disable iff (!rstN)
    vaValid |=> (extAddr[OFF_W-1:0] == $past(va[OFF_W-1:0])));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !vaValid |=> $stable(extAddr));
  p_deny_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && protectOn && !wrPriv) |=> violation);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && protectOn && !wrPriv) |=> !violation);
  p_forward_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vaValid && wrEn && (!protectOn || wrPriv) && (wrIdx == va[VA_W-1 -: SEL_W]))
      |=> (extAddr[EXT_W-1:OFF_W] == $past(wrSid)));
endmodule

bind seg_addr_extender seg_ext_checker #(.VA_W(VA_W), .SEL_W(SEL_W), .SID_W(SID_W)) u_chk (
  .clk(clk), .rstN(rstN), .protectOn(protectOn), .wrEn(wrEn), .wrPriv(wrPriv),
  .wrIdx(wrIdx), .wrSid(wrSid), .vaValid(vaValid), .va(va),
  .extValid(extValid), .extAddr(extAddr), .violation(violation)
);

// File: tb/sim_seg_addr_extender.sv
module sim_seg_addr_extender;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic protectOn = 1'b0, wrEn = 1'b0, wrPriv = 1'b0, vaValid = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [23:0] wrSid = '0;
  logic [31:0] va = '0;
  logic        extValidN, extValidW, violN, violW;
  logic [39:0] extAddrN;
  logic [51:0] extAddrW;

  int checks = 0, failures = 0, cycles = 0;
  logic [23:0] model [16];
  logic [23:0] lastSid = '0;
  logic [27:0] lastOff = '0;

  always #10 clk = ~clk;  // 50 MHz

  seg_addr_extender u0 (
    .clk(clk), .rstN(rstN), .protectOn(protectOn), .wrEn(wrEn), .wrPriv(wrPriv),
    .wrIdx(wrIdx), .wrSid(wrSid[11:0]), .vaValid(vaValid), .va(va),
    .extValid(extValidN), .extAddr(extAddrN), .violation(violN)
  );

  seg_addr_extender #(.SID_W(24)) u1 (
    .clk(clk), .rstN(rstN), .protectOn(protectOn), .wrEn(wrEn), .wrPriv(wrPriv),
    .wrIdx(wrIdx), .wrSid(wrSid), .vaValid(vaValid), .va(va),
    .extValid(extValidW), .extAddr(extAddrW), .violation(violW)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pickSid(input logic [3:0] sel, input bit acc,
                                           input logic [3:0] idx, input logic [23:0] sid);
    return (acc && idx == sel) ? sid : model[sel];
  endfunction

  // drive one cycle at the falling edge, check the registered result one cycle later
  task automatic step(input bit p, input bit we, input bit pr, input logic [3:0] idx,
                      input logic [23:0] sid, input bit vv, input logic [31:0] a, input string tag);
    bit acc;
    bit deny;
    protectOn = p; wrEn = we; wrPriv = pr; wrIdx = idx; wrSid = sid; vaValid = vv; va = a;
    acc  = we && (!p || pr);
    deny = we && p && !pr;
    if (vv) begin
      lastSid = pickSid(a[31:28], acc, idx, sid);
      lastOff = a[27:0];
    end
    @(negedge clk);
    if (acc) model[idx] = sid;
    chk(extValidN == vv && extValidW == vv, "R3", {62'd0, extValidN, extValidW}, {62'd0, vv, vv});
    chk(violN == deny && violW == deny, "R8", {62'd0, violN, violW}, {62'd0, deny, deny});
    chk(extAddrN == {lastSid[11:0], lastOff}, tag, 64'(extAddrN), 64'({lastSid[11:0], lastOff}));
    chk(extAddrW == {lastSid, lastOff}, tag, 64'(extAddrW), 64'({lastSid, lastOff}));
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seedVal = 32'd2024;
    void'($urandom(seedVal));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(extValidN == 0 && violN == 0 && extValidW == 0 && violW == 0, "R1",
        {60'd0, extValidN, violN, extValidW, violW}, 64'd0);
    rstN = 1'b1;
    // R1: every register reads identifier 0
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1, {i[3:0], 28'h0ABCDEF}, "R1");
    // R5 and R4: load all registers unprivileged with protection off, then read back
    for (int i = 0; i < 16; i++) step(0, 1, 0, i[3:0], 24'h5A0000 + 24'(i * 291), 0, 0, "R5");
    for (int i = 15; i >= 0; i--) step(0, 0, 0, 0, 0, 1, {i[3:0], 28'(i * 4099)}, "R4");
    // R6: forwarding to the same index, and no forwarding to a different one
    step(0, 1, 1, 4'd7, 24'hC0FFEE, 1, 32'h7123_4567, "R6");
    step(0, 1, 1, 4'd8, 24'h111111, 1, 32'h9000_0001, "R6");
    step(0, 0, 0, 0, 0, 1, 32'h8000_0002, "R6");
    // R7 and R8: protected unprivileged write refused, register unchanged
    step(1, 1, 0, 4'd3, 24'hDEAD01, 1, 32'h3000_0010, "R7");
    step(1, 1, 0, 4'd3, 24'hDEAD02, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 1, 32'h3FFF_FFFF, "R7");
    // R9: protected privileged write accepted, forwarded and stored
    step(1, 1, 1, 4'd3, 24'hBEEF99, 1, 32'h3000_0020, "R9");
    step(1, 0, 0, 0, 0, 1, 32'h3000_0030, "R9");
    // R10: output held while idle
    step(0, 1, 0, 4'd3, 24'h000123, 0, 32'hFFFF_FFFF, "R10");
    step(0, 0, 0, 0, 0, 0, 32'h1234_5678, "R10");
    // R2: seeded random mix
    for (int n = 0; n < 400; n++) begin
      step(bit'($urandom % 2), ($urandom % 3) != 0, bit'($urandom % 2), 4'($urandom),
           24'($urandom), ($urandom % 4) != 0, $urandom, "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule